// File: doc/BRIEF.md
# Register-Mapped Short-Burst SPI Master

This block is a single-target SPI master for short command transactions such as flash reads, status polls and register accesses. Software puts up to eight outgoing bytes into two 32-bit data registers and writes a control word that holds a send count, a receive count and a start bit. The engine shifts the send bytes out MSB first. It then clocks in up to eight bytes from the target and places them back into the same two registers. A busy flag in the control word tells software when the results are ready.

The chip select is a plain register bit, so software can hold the target selected across several bursts. The serial clock comes from the bus clock through a programmable divider. The bus side is a simple register port with an address, a write enable, write data and read data. Reads are combinational by default. A parameter can add one register stage to the read data.

Top module: `spi_burst_master`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0 and `spi_mosi` is 0. The busy bit reads 0, and the configuration register at 0x28 reads 0x0003_0000, which is a divider value of 3 in bits 27:16.
- R2: The control register at 0x00 holds the send count in bits 3:0 and the receive count in bits 7:4, and both read back. Writing 1 to bit 8 starts a transfer, and bit 8 always reads 0. Bit 16 reads 1 from the cycle after the starting write, for exactly 8·(send+receive)·(divider+2) cycles, and then reads 0.
- R3: Send byte k goes out on `spi_mosi` MSB first. The bytes are taken in this order: k=0 from 0x04[7:0], k=1 from 0x04[31:24], k=2 from 0x04[23:16], k=3 from 0x04[15:8], k=4 from 0x08[7:0], k=5 from 0x08[15:8], k=6 from 0x08[23:16], k=7 from 0x08[31:24].
- R4: Received byte k is assembled MSB first. Bytes 0 to 3 land in 0x08 at bits [8k+7:8k], and bytes 4 to 7 land in 0x04 at bits [8(k-4)+7:8(k-4)]. Byte slots at or beyond the receive count keep their previous contents.
- R5: The bus uses SPI mode 0. SCK idles low, MOSI changes only while SCK is low, and MISO is sampled on the rising SCK edge. All send bits go out before the first receive bit, and MOSI is 0 while bytes are being received.
- R6: One SCK period is divider+2 bus cycles, with floor((divider+2)/2) cycles high. A transfer produces exactly 8·(send+receive) rising SCK edges.
- R7: Bit 0 of register 0x38 drives the chip select: 1 makes `spi_cs_n` 0 and 0 makes it 1. The chip select does not change when a transfer starts or finishes.
- R8: A control-register write while busy is ignored. This covers the start bit and both counts.
- R9: A count field written above 8 is stored and used as 8.
- R10: A start with both counts zero produces no SCK edge, and busy stays 0.
- R11: Reads of any address other than 0x00, 0x04, 0x08, 0x28 and 0x38 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register byte address |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the target |
| spi_miso | input | 1 | Serial data from the target |

## Verification
The bench uses distinct byte values so that any swap of the middle send bytes shows up as a wrong byte on MOSI. A design that packed the bytes in natural order would send 0x11,0x44,0x33,0x22 instead of 0x11,0x22,0x33,0x44.

It runs partial receives over preloaded sentinel values. A design that cleared whole registers, or that wrote receive byte 0 into the opcode register, would corrupt slots it should leave alone.

It also covers the following cases:
- The busy length at several divider values. An off-by-one in the period count changes the busy length and the spacing between rising edges.
- A restart written mid-transfer. A design that accepts it would add pulses or change the stored counts.
- Oversized count fields. Without the clamp they would produce 120 pulses rather than 64.
- A zero-length start. A design that treats it as a transfer would raise busy or emit a stray SCK edge.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

   // Register offsets; the transfer engine and software agree on these.
   localparam logic [7:0] OFF_CTRL = 8'h00;
   localparam logic [7:0] OFF_OPC  = 8'h04;
   localparam logic [7:0] OFF_DAT  = 8'h08;
   localparam logic [7:0] OFF_CFG  = 8'h28;
   localparam logic [7:0] OFF_CS   = 8'h38;

   localparam int REG_W     = 32;
   localparam int BIT_START = 8;
   localparam int BIT_BUSY  = 16;
   localparam int DIV_LSB   = 16;
   localparam int NBYTES    = 8;      // bytes per direction
   localparam int CNT_W     = 4;      // count field width

   typedef struct packed {
      logic [CNT_W-1:0] rx;
      logic [CNT_W-1:0] tx;
   } xfer_cnt_t;

endpackage

// File: rtl/spi_burst_clkgen.sv
module spi_burst_clkgen #(
   parameter int DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             sck,
   output logic             rise,
   output logic             fall
);
   localparam int CW = DIV_W + 1;

   logic [CW-1:0] period, hi_len, lo_len, cnt;

   always_comb begin
      period = CW'(div) + CW'(2);
      hi_len = period >> 1;
      lo_len = period - hi_len;
      rise   = run && !sck && (cnt == lo_len - CW'(1));
      fall   = run &&  sck && (cnt == hi_len - CW'(1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck <= 1'b0;
         cnt <= '0;
      end else if (!run) begin
         sck <= 1'b0;
         cnt <= '0;
      end else if (rise || fall) begin
         sck <= !sck;
         cnt <= '0;
      end else begin
         cnt <= cnt + CW'(1);
      end
   end

   // A high phase is never longer than its programmed length (R6)
   assert_high_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sck && run) |-> (cnt < hi_len));

endmodule

// File: rtl/spi_burst_shifter.sv
module spi_burst_shifter
   import spi_burst_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  xfer_cnt_t             cnt,
   input  logic [8*NBYTES-1:0]   tx_stream,
   input  logic                  rise,
   input  logic                  fall,
   input  logic                  miso,
   output logic                  busy,
   output logic                  mosi,
   output logic                  rx_we,
   output logic [$clog2(NBYTES)-1:0] rx_slot,
   output logic [7:0]            rx_byte
);
   localparam int TOT_W  = $clog2(16*NBYTES + 1);
   localparam int SLOT_W = $clog2(NBYTES);
   localparam int SR_W   = 8*NBYTES;

   logic [TOT_W-1:0] bit_idx, last_idx, tx_bits, rx_pos, next_idx, total_bits;
   logic [SR_W-1:0]  txsr;
   logic [6:0]       rxsr;
   logic             in_rx;

   always_comb begin
      total_bits = (TOT_W'(cnt.tx) + TOT_W'(cnt.rx)) << 3;
      in_rx      = (bit_idx >= tx_bits);
      rx_pos     = bit_idx - tx_bits;
      next_idx   = bit_idx + TOT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         mosi     <= 1'b0;
         bit_idx  <= '0;
         last_idx <= '0;
         tx_bits  <= '0;
         txsr     <= '0;
         rxsr     <= '0;
         rx_we    <= 1'b0;
         rx_slot  <= '0;
         rx_byte  <= '0;
      end else begin
         rx_we <= 1'b0;
         if (start && !busy && (total_bits != '0)) begin
            busy     <= 1'b1;
            bit_idx  <= '0;
            tx_bits  <= TOT_W'(cnt.tx) << 3;
            last_idx <= total_bits - TOT_W'(1);
            txsr     <= tx_stream;
            mosi     <= (cnt.tx != '0) ? tx_stream[SR_W-1] : 1'b0;
         end else if (busy) begin
            if (rise && in_rx) begin
               rxsr <= {rxsr[5:0], miso};
               if (bit_idx[2:0] == 3'd7) begin
                  rx_we   <= 1'b1;
                  rx_byte <= {rxsr, miso};
                  rx_slot <= SLOT_W'(rx_pos >> 3);
               end
            end
            if (fall) begin
               if (bit_idx == last_idx) begin
                  busy <= 1'b0;
                  mosi <= 1'b0;
               end else begin
                  bit_idx <= next_idx;
                  txsr    <= txsr << 1;
                  mosi    <= (next_idx < tx_bits) ? txsr[SR_W-2] : 1'b0;
               end
            end
         end
      end
   end

   // Nothing but zeros leaves on MOSI once receiving has begun (R5)
   assert_mosi_quiet_rx_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && in_rx) |-> !mosi);

   // A received byte is only ever delivered while a transfer runs (R4)
   assert_rx_in_xfer_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_we |-> $past(busy));

endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
   import spi_burst_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DIV_W     = 12,
   parameter int DIV_RESET = 3,
   parameter bit RDATA_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              spi_sck,
   output logic              spi_cs_n,
   output logic              spi_mosi,
   input  logic              spi_miso
);
   localparam int SLOT_W = $clog2(NBYTES);

   generate
      if (DIV_W < 1 || DIV_W > 12) begin : g_bad_div
         $error("DIV_W must lie in 1..12");
      end
      if (ADDR_W < 6) begin : g_bad_addr
         $error("ADDR_W must cover offset 0x38");
      end
      if (DIV_RESET < 0 || DIV_RESET >= (1 << DIV_W)) begin : g_bad_rst
         $error("DIV_RESET does not fit DIV_W");
      end
   endgenerate

   xfer_cnt_t           cnt_q;
   logic [31:0]         opc_q, dat_q, rd_mux;
   logic [DIV_W-1:0]    div_q;
   logic                cs_q, busy, start_go, rise, fall;
   logic                wr_ctrl, wr_opc, wr_dat, wr_cfg, wr_cs;
   logic                rx_we;
   logic [SLOT_W-1:0]   rx_slot;
   logic [7:0]          rx_byte;
   logic [8*NBYTES-1:0] tx_stream;

   function automatic logic [CNT_W-1:0] clamp(input logic [CNT_W-1:0] v);
      return (v > CNT_W'(NBYTES)) ? CNT_W'(NBYTES) : v;
   endfunction

   always_comb begin
      wr_ctrl  = reg_we && (reg_addr == ADDR_W'(OFF_CTRL));
      wr_opc   = reg_we && (reg_addr == ADDR_W'(OFF_OPC));
      wr_dat   = reg_we && (reg_addr == ADDR_W'(OFF_DAT));
      wr_cfg   = reg_we && (reg_addr == ADDR_W'(OFF_CFG));
      wr_cs    = reg_we && (reg_addr == ADDR_W'(OFF_CS));
      start_go = wr_ctrl && !busy && reg_wdata[BIT_START];
      // Send order: first opcode byte, then opcode's upper bytes high to low,
      // then the data register low to high.
      tx_stream = {opc_q[7:0], opc_q[31:24], opc_q[23:16], opc_q[15:8],
                   dat_q[7:0], dat_q[15:8], dat_q[23:16], dat_q[31:24]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         div_q <= DIV_W'(DIV_RESET);
         cs_q  <= 1'b0;
         opc_q <= '0;
         dat_q <= '0;
      end else begin
         if (wr_ctrl && !busy) begin
            cnt_q.tx <= clamp(reg_wdata[3:0]);
            cnt_q.rx <= clamp(reg_wdata[7:4]);
         end
         if (wr_cfg) div_q <= reg_wdata[DIV_LSB +: DIV_W];
         if (wr_cs)  cs_q  <= reg_wdata[0];
         if (wr_opc) opc_q <= reg_wdata;
         if (wr_dat) dat_q <= reg_wdata;
         if (rx_we) begin
            if (rx_slot[SLOT_W-1]) opc_q[{rx_slot[1:0], 3'b000} +: 8] <= rx_byte;
            else                   dat_q[{rx_slot[1:0], 3'b000} +: 8] <= rx_byte;
         end
      end
   end

   xfer_cnt_t start_cnt;
   always_comb begin
      start_cnt.tx = clamp(reg_wdata[3:0]);
      start_cnt.rx = clamp(reg_wdata[7:4]);
   end

   spi_burst_clkgen #(.DIV_W(DIV_W)) u_clk (
      .clk (clk), .rst_n (rst_n), .run (busy), .div (div_q),
      .sck (spi_sck), .rise (rise), .fall (fall)
   );

   spi_burst_shifter u_shift (
      .clk (clk), .rst_n (rst_n), .start (start_go), .cnt (start_cnt),
      .tx_stream (tx_stream), .rise (rise), .fall (fall), .miso (spi_miso),
      .busy (busy), .mosi (spi_mosi), .rx_we (rx_we), .rx_slot (rx_slot),
      .rx_byte (rx_byte)
   );

   assign spi_cs_n = !cs_q;

   always_comb begin
      rd_mux = '0;
      if (reg_addr == ADDR_W'(OFF_CTRL)) begin
         rd_mux[BIT_BUSY] = busy;
         rd_mux[7:0]      = cnt_q;
      end else if (reg_addr == ADDR_W'(OFF_OPC)) begin
         rd_mux = opc_q;
      end else if (reg_addr == ADDR_W'(OFF_DAT)) begin
         rd_mux = dat_q;
      end else if (reg_addr == ADDR_W'(OFF_CFG)) begin
         rd_mux[DIV_LSB +: DIV_W] = div_q;
      end else if (reg_addr == ADDR_W'(OFF_CS)) begin
         rd_mux[0] = cs_q;
      end
   end

   generate
      if (RDATA_REG) begin : g_rd_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) reg_rdata <= '0;
            else        reg_rdata <= rd_mux;
         end
      end else begin : g_rd_comb
         assign reg_rdata = rd_mux;
      end
   endgenerate

   assert_cs_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cs |=> (spi_cs_n == !$past(reg_wdata[0])));

   assert_sck_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !spi_sck);

   assert_mosi_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(spi_mosi) |-> !spi_sck);

   assert_busy_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start_go));

   assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && busy) |=> (cnt_q == $past(cnt_q)));

   assert_count_clamp_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q.tx <= CNT_W'(NBYTES)) && (cnt_q.rx <= CNT_W'(NBYTES)));

endmodule

// File: tb/tb_spi_burst_master.sv
module tb_spi_burst_master;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, spi_miso = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic        spi_sck, spi_cs_n, spi_mosi;

   int tests = 0, fails = 0;
   int cyc = 0, rises = 0, hi_cyc = 0, rise_c0 = 0, rise_c1 = 0;
   logic         sck_prev = 1'b0;
   logic [127:0] stream = '0, cap = '0;

   spi_burst_master dut (
      .clk (clk), .rst_n (rst_n), .reg_addr (reg_addr), .reg_we (reg_we),
      .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .spi_sck (spi_sck),
      .spi_cs_n (spi_cs_n), .spi_mosi (spi_mosi), .spi_miso (spi_miso)
   );

   always #(CLK_PERIOD/2) clk = !clk;

   // Target model and line monitor, sampled mid-cycle
   always @(negedge clk) begin
      cyc++;
      if (spi_sck) hi_cyc++;
      if (spi_sck && !sck_prev) begin
         if (rises < 128) cap[rises] = spi_mosi;
         if (rises == 0) rise_c0 = cyc;
         if (rises == 1) rise_c1 = cyc;
         rises++;
      end
      if (!spi_sck && sck_prev && rises < 128) spi_miso = stream[rises];
      sck_prev = spi_sck;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: all requirements, got timeout, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   function automatic logic [31:0] pack_opc(input logic [7:0] b [8]);
      return {b[1], b[2], b[3], b[0]};
   endfunction

   function automatic logic [31:0] pack_dat(input logic [7:0] b [8]);
      return {b[7], b[6], b[5], b[4]};
   endfunction

   // Runs one transfer; returns the number of cycles busy read as 1.
   task automatic xfer(input int txn, input int rxn, input int div,
                       input logic [7:0] rxb [8], output int busy_n);
      logic [31:0] r;
      stream = '0;
      for (int k = 0; k < rxn && k < 8; k++)
         for (int j = 0; j < 8; j++) stream[txn*8 + 8*k + j] = rxb[k][7-j];
      spi_miso = stream[0];
      rises = 0; hi_cyc = 0; cap = '0; rise_c0 = 0; rise_c1 = 0;
      wr(8'h28, 32'(div) << 16);
      wr(8'h00, 32'h100 | (32'(rxn) << 4) | 32'(txn));
      busy_n = 0;
      for (int i = 0; i < 20000; i++) begin
         rd(8'h00, r);
         if (!r[16]) break;
         busy_n++;
         @(negedge clk);
      end
      @(negedge clk);
   endtask

   function automatic logic [7:0] cap_byte(input int k);
      logic [7:0] v;
      for (int j = 0; j < 8; j++) v[7-j] = cap[8*k + j];
      return v;
   endfunction

   task automatic t_reset;
      logic [31:0] r;
      chk("R1 cs_n", 32'(spi_cs_n), 32'd1);
      chk("R1 sck", 32'(spi_sck), 32'd0);
      chk("R1 mosi", 32'(spi_mosi), 32'd0);
      rd(8'h00, r); chk("R1 ctrl", r, 32'h0);
      rd(8'h28, r); chk("R1 cfg", r, 32'h0003_0000);
   endtask

   task automatic t_cs;
      wr(8'h38, 32'h1); chk("R7 cs on", 32'(spi_cs_n), 32'd0);
      wr(8'h38, 32'h0); chk("R7 cs off", 32'(spi_cs_n), 32'd1);
      wr(8'h38, 32'h1);
   endtask

   task automatic t_tx8;
      logic [7:0] b [8] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88};
      logic [7:0] z [8] = '{default: 8'h00};
      logic [31:0] r; int bn;
      wr(8'h04, pack_opc(b)); wr(8'h08, pack_dat(b));
      xfer(8, 0, 3, z, bn);
      for (int k = 0; k < 8; k++) chk($sformatf("R3 tx byte %0d", k), 32'(cap_byte(k)), 32'(b[k]));
      chk("R6 rises tx8", 32'(rises), 32'd64);
      chk("R2 busy len div3", 32'(bn), 32'(64*5));
      chk("R6 high cycles div3", 32'(hi_cyc), 32'(64*2));
      chk("R6 period div3", 32'(rise_c1 - rise_c0), 32'd5);
      rd(8'h00, r); chk("R2 ctrl readback", r, 32'h0000_0008);
      chk("R7 cs held", 32'(spi_cs_n), 32'd0);
   endtask

   task automatic t_rx3;
      logic [7:0] b [8] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88};
      logic [7:0] rx [8] = '{8'hA5, 8'h3C, 8'h0F, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
      logic [31:0] r; int bn;
      wr(8'h04, pack_opc(b)); wr(8'h08, pack_dat(b));
      xfer(2, 3, 0, rx, bn);
      chk("R3 tx byte0 short", 32'(cap_byte(0)), 32'h11);
      chk("R3 tx byte1 short", 32'(cap_byte(1)), 32'h22);
      chk("R5 mosi zero in rx", 32'(cap[39:16]), 32'h0);
      chk("R2 busy len div0", 32'(bn), 32'(40*2));
      chk("R6 high cycles div0", 32'(hi_cyc), 32'd40);
      rd(8'h08, r); chk("R4 data partial", r, {8'h88, 8'h0F, 8'h3C, 8'hA5});
      rd(8'h04, r); chk("R4 opcode kept", r, pack_opc(b));
   endtask

   task automatic t_rx8;
      logic [7:0] rx [8] = '{8'h01, 8'h82, 8'hC3, 8'h24, 8'h5A, 8'hE6, 8'h97, 8'hF8};
      logic [31:0] r; int bn;
      wr(8'h04, 32'hDEAD_BEEF); wr(8'h08, 32'hCAFE_F00D);
      xfer(1, 8, 4, rx, bn);
      chk("R3 tx byte0 only", 32'(cap_byte(0)), 32'hEF);
      chk("R5 mosi zero in rx8", 32'(cap[71:8] != 64'h0), 32'd0);
      chk("R6 period div4", 32'(rise_c1 - rise_c0), 32'd6);
      chk("R6 high cycles div4", 32'(hi_cyc), 32'(72*3));
      rd(8'h08, r); chk("R4 rx bytes 0-3", r, {rx[3], rx[2], rx[1], rx[0]});
      rd(8'h04, r); chk("R4 rx bytes 4-7", r, {rx[7], rx[6], rx[5], rx[4]});
   endtask

   task automatic t_restart;
      logic [31:0] r;
      stream = '0; rises = 0;
      wr(8'h28, 32'h0003_0000);
      wr(8'h00, 32'h104);
      repeat (10) @(negedge clk);
      wr(8'h00, 32'h111);
      rd(8'h00, r); chk("R8 counts kept", 32'(r[7:0]), 32'h04);
      for (int i = 0; i < 2000; i++) begin
         rd(8'h00, r);
         if (!r[16]) break;
         @(negedge clk);
      end
      repeat (20) @(negedge clk);
      chk("R8 pulses unchanged", 32'(rises), 32'd32);
   endtask

   task automatic t_clamp;
      logic [7:0] z [8] = '{default: 8'h00};
      logic [31:0] r; int bn;
      xfer(15, 0, 1, z, bn);
      chk("R9 clamped pulses", 32'(rises), 32'd64);
      rd(8'h00, r); chk("R9 clamped field", 32'(r[7:0]), 32'h08);
      chk("R6 period div1", 32'(rise_c1 - rise_c0), 32'd3);
   endtask

   task automatic t_zero;
      logic [7:0] z [8] = '{default: 8'h00};
      int bn;
      xfer(0, 0, 3, z, bn);
      repeat (10) @(negedge clk);
      chk("R10 no busy", 32'(bn), 32'd0);
      chk("R10 no sck", 32'(rises), 32'd0);
   endtask

   task automatic t_map;
      logic [31:0] r;
      wr(8'h28, 32'h0ABC_0000);
      rd(8'h28, r); chk("R11 cfg readback", r, 32'h0ABC_0000);
      rd(8'h10, r); chk("R11 unmapped 0x10", r, 32'h0);
      rd(8'h3C, r); chk("R11 unmapped 0x3C", r, 32'h0);
      rd(8'h38, r); chk("R11 cs readback", r, 32'h1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_cs;
      t_tx8;
      t_rx3;
      t_rx8;
      t_restart;
      t_clamp;
      t_zero;
      t_map;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule